// File: doc/BRIEF.md
# Comparator Control Register Bank

This block keeps the control state for a set of comparator channels, two by default. Each channel has one working control register and four data registers beside it. A serial front end decodes each host instruction into an opcode, a register select and a channel select, with an optional data byte, and presents them with a one-cycle strobe. The host can write or read the working register and the data registers directly. A transfer instruction copies a data register into the working register, or copies the working register into a data register, without a data byte.

The working register's low three bits set how each channel's comparator result reaches its pin. Enable lets the result drive the pin and raises an output-enable. Latch freezes the result that was present at the clock edge where Latch was set. Shutdown raises a power-down output and forces the pin low, because the result is then not valid. The analog comparator is outside the block and arrives as one digital input bit per channel.

Top module: `cmp_ctrl_bank`

## Requirements
- R1: After reset every working register and data register reads 0, and every `cmp_out`, `cmp_oe` and `ana_pwrdn` bit is 0.
- R2: Working-register bit 0 is Enable. While it is 0 the channel's `cmp_out` is 0 and `cmp_oe` is 0. While it is 1, `cmp_oe` is 1.
- R3: With Enable 1, Latch (bit 1) 0 and Shutdown (bit 2) 0, `cmp_out` follows the channel's `cmp_in` bit combinationally, within the same cycle.
- R4: With Latch 1, `cmp_out` shows the `cmp_in` value sampled at the clock edge where Latch went from 0 to 1. It holds that value while Latch stays 1 and follows `cmp_in` again once Latch is 0.
- R5: `ana_pwrdn` equals Shutdown (bit 2). While Shutdown is 1, `cmp_out` is 0.
- R6: Opcode 0x2 with strobe writes `ins_wdata` into the working register of channel `ins_csel`, effective at that clock edge.
- R7: Opcode 0x4 writes `ins_wdata` into data register `ins_rsel`. Opcode 0x1 reads the working register and opcode 0x3 reads data register `ins_rsel`. After the strobe edge, `rd_data` carries the value and `rd_valid` is 1 for exactly one cycle.
- R8: Opcode 0x5 copies data register `ins_rsel` into the working register. Opcode 0x6 copies the working register into data register `ins_rsel`. `ins_wdata` is not used by either.
- R9: A strobe with opcode 0x0 or 0x7 to 0xF, or with `ins_csel` of 2 or 3, changes no register, and `rd_valid` stays 0.
- R10: An instruction to one channel leaves the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_stb | input | 1 | One-cycle instruction strobe |
| ins_op | input | 4 | Decoded opcode |
| ins_rsel | input | 2 | Data register select |
| ins_csel | input | 2 | Channel select |
| ins_wdata | input | 8 | Data byte for write opcodes |
| cmp_in | input | 2 | Digital comparator result per channel |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid, one cycle |
| cmp_out | output | 2 | Conditioned comparator pin per channel |
| cmp_oe | output | 2 | Pin output-enable per channel |
| ana_pwrdn | output | 2 | Analog power-down per channel |

## Verification
Two functions can meet in one cycle: a register update that sets Latch, by direct write or by transfer, and a change of the live comparator input on the same clock edge. The bench drives a new `cmp_in` value together with the strobe that raises Latch. It expects the frozen pin to show the value present at that edge, not the value before it. It then toggles `cmp_in` between edges to confirm the pin stays frozen until Latch clears. Random runs mix transfers into the working register with input changes, and a bench model predicts every pin.

// File: rtl/cmpbank_pkg.sv
package cmpbank_pkg;
  localparam logic [3:0] OP_RD_ACR = 4'h1;
  localparam logic [3:0] OP_WR_ACR = 4'h2;
  localparam logic [3:0] OP_RD_DR  = 4'h3;
  localparam logic [3:0] OP_WR_DR  = 4'h4;
  localparam logic [3:0] OP_DR2ACR = 4'h5;
  localparam logic [3:0] OP_ACR2DR = 4'h6;

  localparam int BIT_EN  = 0;
  localparam int BIT_LAT = 1;
  localparam int BIT_SD  = 2;

  function automatic logic gate_pin(input logic en, input logic sd, input logic lat,
                                    input logic held, input logic live);
    return en & ~sd & (lat ? held : live);
  endfunction

  function automatic logic is_read(input logic [3:0] op);
    return (op == OP_RD_ACR) || (op == OP_RD_DR);
  endfunction
endpackage

// File: rtl/cbk_gate.sv
module cbk_gate
  import cmpbank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lat,
  input  logic sd,
  input  logic live,
  output logic pin,
  output logic oe,
  output logic pwrdn
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else if (!lat) hold_q <= live;
  end

  assign pin   = gate_pin(en, sd, lat, hold_q, live);
  assign oe    = en;
  assign pwrdn = sd;

  // R2
  dis_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pin && !oe));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lat && !sd && $past(en) && $past(lat) && $past(!sd)) |-> $stable(pin));
  // R5
  sd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd |-> (pwrdn && !pin));
endmodule

// File: rtl/cbk_chan.sv
module cbk_chan
  import cmpbank_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NDR = 4,
  localparam int RSW = $clog2(NDR)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic [3:0]     op,
  input  logic [RSW-1:0] rsel,
  input  logic [DW-1:0]  wdata,
  input  logic           live,
  output logic [DW-1:0]  rd_val,
  output logic           pin,
  output logic           oe,
  output logic           pwrdn
);
  logic [DW-1:0] acr_q;
  logic [DW-1:0] dr_q [NDR];
  logic [DW-1:0] dr_pick;
  logic          acr_load;

  assign dr_pick  = dr_q[rsel];
  assign acr_load = hit && ((op == OP_WR_ACR) || (op == OP_DR2ACR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acr_q <= '0;
      for (int i = 0; i < NDR; i++) dr_q[i] <= '0;
    end else if (hit) begin
      case (op)
        OP_WR_ACR: acr_q <= wdata;
        OP_DR2ACR: acr_q <= dr_pick;
        OP_WR_DR:  dr_q[rsel] <= wdata;
        OP_ACR2DR: dr_q[rsel] <= acr_q;
        default: ;
      endcase
    end
  end

  assign rd_val = (op == OP_RD_ACR) ? acr_q : dr_pick;

  cbk_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .en(acr_q[BIT_EN]), .lat(acr_q[BIT_LAT]), .sd(acr_q[BIT_SD]),
    .live(live), .pin(pin), .oe(oe), .pwrdn(pwrdn)
  );

  // R6
  wr_acr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_WR_ACR) |=> (acr_q == $past(wdata)));
  // R8
  xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_DR2ACR) |=> (acr_q == $past(dr_pick)));
  // R9
  acr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acr_load |=> $stable(acr_q));
endmodule

// File: rtl/cmp_ctrl_bank.sv
module cmp_ctrl_bank
  import cmpbank_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NDR = 4,
  parameter int NCH = 2,
  parameter int CSW = 2,
  localparam int RSW = $clog2(NDR)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ins_stb,
  input  logic [3:0]     ins_op,
  input  logic [RSW-1:0] ins_rsel,
  input  logic [CSW-1:0] ins_csel,
  input  logic [DW-1:0]  ins_wdata,
  input  logic [NCH-1:0] cmp_in,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic [NCH-1:0] cmp_out,
  output logic [NCH-1:0] cmp_oe,
  output logic [NCH-1:0] ana_pwrdn
);
  logic [DW-1:0] ch_rd [NCH];
  logic [DW-1:0] rd_sel;
  logic          ch_ok;
  logic          rd_hit;

  assign ch_ok = int'(ins_csel) < NCH;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cbk_chan #(.DW(DW), .NDR(NDR)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .hit(ins_stb && (int'(ins_csel) == c)),
      .op(ins_op), .rsel(ins_rsel), .wdata(ins_wdata),
      .live(cmp_in[c]), .rd_val(ch_rd[c]),
      .pin(cmp_out[c]), .oe(cmp_oe[c]), .pwrdn(ana_pwrdn[c])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NCH; c++)
      if (int'(ins_csel) == c) rd_sel = ch_rd[c];
  end

  assign rd_hit = ins_stb && ch_ok && is_read(ins_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) rd_data <= rd_sel;
    end
  end

  // R7
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stb && ch_ok && (ins_op == OP_RD_ACR || ins_op == OP_RD_DR)) |=> rd_valid);
  // R9
  no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_stb && ch_ok && (ins_op == OP_RD_ACR || ins_op == OP_RD_DR)) |=> !rd_valid);
endmodule

// File: tb/tb_cmp_ctrl_bank.sv
module tb_cmp_ctrl_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_stb = 1'b0;
  logic [3:0] ins_op = '0;
  logic [1:0] ins_rsel = '0, ins_csel = '0;
  logic [7:0] ins_wdata = '0;
  logic [1:0] cmp_in = '0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [1:0] cmp_out, cmp_oe, ana_pwrdn;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] acr_m [2];
  logic [7:0] dr_m [2][4];
  logic hold_m [2];
  logic [7:0] exp_rd;
  logic exp_rv;

  always #4 clk = ~clk;

  cmp_ctrl_bank dut (.*);

  function automatic logic exp_pin(input int c);
    logic [7:0] a = acr_m[c];
    if (!a[0] || a[2]) return 1'b0;
    return a[1] ? hold_m[c] : cmp_in[c];
  endfunction

  function automatic string tag(input int c);
    logic [7:0] a = acr_m[c];
    if (!a[0]) return "R2";
    if (a[2]) return "R5";
    if (a[1]) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic check_pins();
    for (int c = 0; c < 2; c++) begin
      chk(tag(c), {7'd0, cmp_out[c]}, {7'd0, exp_pin(c)});
      chk("R2", {7'd0, cmp_oe[c]}, {7'd0, acr_m[c][0]});
      chk("R5", {7'd0, ana_pwrdn[c]}, {7'd0, acr_m[c][2]});
    end
  endtask

  // drive one cycle at negedge, model the edge, check at the next negedge
  task automatic step(input logic stb, input logic [3:0] op, input logic [1:0] cs,
                      input logic [1:0] rs, input logic [7:0] wd, input logic [1:0] cin);
    ins_stb = stb; ins_op = op; ins_csel = cs; ins_rsel = rs; ins_wdata = wd; cmp_in = cin;
    for (int c = 0; c < 2; c++) if (!acr_m[c][1]) hold_m[c] = cin[c];
    exp_rv = 1'b0;
    if (stb && cs < 2) begin
      case (op)
        4'h1: begin exp_rd = acr_m[cs]; exp_rv = 1'b1; end
        4'h2: acr_m[cs] = wd;
        4'h3: begin exp_rd = dr_m[cs][rs]; exp_rv = 1'b1; end
        4'h4: dr_m[cs][rs] = wd;
        4'h5: acr_m[cs] = dr_m[cs][rs];
        4'h6: dr_m[cs][rs] = acr_m[cs];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    ins_stb = 1'b0;
    chk(exp_rv ? "R7" : "R9", {7'd0, rd_valid}, {7'd0, exp_rv});
    if (exp_rv) chk("R7", rd_data, exp_rd);
    check_pins();
  endtask

  task automatic rd(input logic [3:0] op, input logic [1:0] cs, input logic [1:0] rs);
    step(1'b1, op, cs, rs, 8'h00, cmp_in);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      acr_m[c] = '0; hold_m[c] = 1'b0;
      for (int r = 0; r < 4; r++) dr_m[c][r] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    chk("R1", {cmp_out, cmp_oe, ana_pwrdn, rd_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all registers read zero
    for (int c = 0; c < 2; c++) begin
      rd(4'h1, 2'(c), 2'd0);
      chk("R1", rd_data, 8'h00);
      for (int r = 0; r < 4; r++) begin
        rd(4'h3, 2'(c), 2'(r));
        chk("R1", rd_data, 8'h00);
      end
    end
    // R3: enable channel 0, pin follows cmp_in within the cycle
    step(1'b1, 4'h2, 2'd0, 2'd0, 8'h01, 2'b00);
    cmp_in = 2'b01; #1;
    chk("R3", {7'd0, cmp_out[0]}, 8'h01);
    @(negedge clk);
    // R4: latch set in the same edge as cmp_in rises
    step(1'b1, 4'h2, 2'd0, 2'd0, 8'h00, 2'b00);
    step(1'b1, 4'h2, 2'd0, 2'd0, 8'h03, 2'b01);
    chk("R4", {7'd0, cmp_out[0]}, 8'h01);
    cmp_in = 2'b00; #1;
    chk("R4", {7'd0, cmp_out[0]}, 8'h01);
    @(negedge clk);
    step(1'b0, 4'h0, 2'd0, 2'd0, 8'h00, 2'b00);
    chk("R4", {7'd0, cmp_out[0]}, 8'h01);
    // R4: latch cleared, tracking resumes
    step(1'b1, 4'h2, 2'd0, 2'd0, 8'h01, 2'b00);
    chk("R4", {7'd0, cmp_out[0]}, 8'h00);
    // R8: transfer with latch from data register, wdata ignored
    step(1'b1, 4'h4, 2'd0, 2'd2, 8'h07, 2'b11);
    step(1'b1, 4'h5, 2'd0, 2'd2, 8'hF0, 2'b11);
    rd(4'h1, 2'd0, 2'd0);
    chk("R8", rd_data, 8'h07);
    step(1'b1, 4'h6, 2'd0, 2'd1, 8'h55, 2'b11);
    rd(4'h3, 2'd0, 2'd1);
    chk("R8", rd_data, 8'h07);
    // R5: shutdown forces pin low, pwrdn high
    step(1'b1, 4'h2, 2'd1, 2'd0, 8'h05, 2'b11);
    chk("R5", {7'd0, cmp_out[1]}, 8'h00);
    chk("R5", {7'd0, ana_pwrdn[1]}, 8'h01);
    // R10: channel 1 write left channel 0 alone
    rd(4'h1, 2'd0, 2'd0);
    chk("R10", rd_data, 8'h07);
    // R9: invalid channel and invalid opcode change nothing
    step(1'b1, 4'h2, 2'd3, 2'd0, 8'hFF, 2'b11);
    step(1'b1, 4'h9, 2'd0, 2'd0, 8'hFF, 2'b11);
    rd(4'h1, 2'd0, 2'd0);
    chk("R9", rd_data, 8'h07);
    rd(4'h1, 2'd1, 2'd0);
    chk("R9", rd_data, 8'h05);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 7));
      logic [1:0] cs = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      logic [7:0] wd = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 7));
      step(1'($urandom_range(0, 3) != 0), op, cs, 2'($urandom), wd, 2'($urandom));
      cmp_in = 2'($urandom); #1;
      check_pins();
      @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule